// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive on behalf of a memory controller. Out of reset it holds off all traffic for a programmable power-up pause. It then runs a burst of wake-up refresh cycles on the row and column strobes, and only after that does it raise a ready output that lets normal accesses begin. In service it counts refresh intervals, asks the controller for the strobe pins through a request/grant handshake, and on grant performs one CAS-before-RAS refresh. The device supplies the row itself in that mode, so no address, write-enable or output-enable drive is needed.

Refreshes that fall due but are not yet serviced are counted. If a new interval expires while the count already sits at its limit, the retention window is treated as broken. The block then drops ready, raises an overrun flag, takes the pins through the same handshake and runs a full wake-up burst again before it restores ready. All timing is expressed in clock cycles through parameters, which are derived from the nanosecond limits of the memory at the chosen clock rate.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is high and on the cycle after it, seq_ready, ref_req and overrun are 0, both strobes are 1 and pin_own is 1.
- R2: After reset is released, the first strobe activity (column strobe falling) occurs no sooner than PAUSE_CYC cycles and no later than PAUSE_CYC+2 cycles later.
- R3: Before seq_ready first rises, and again during overrun recovery, exactly WAKE_CYCLES refresh cycles are run; ref_req stays 0 while seq_ready and overrun are both 0.
- R4: Each refresh cycle drives the column strobe low at least CSR_CYC cycles before the row strobe falls, and keeps it low for exactly CHR_CYC cycles after that fall.
- R5: The row strobe stays low for exactly RAS_CYC cycles per refresh, and stays high for at least max(RP_CYC, CP_CYC) cycles before it falls again. The column strobe is high for at least CP_CYC cycles before each fall.
- R6: In service, one refresh falls due every REFI_CYC cycles, counted from the rise of seq_ready. The first ref_req rises exactly REFI_CYC+1 cycles after seq_ready rises, and the k-th serviced refresh cannot start its row strobe before k*REFI_CYC+2+CSR_CYC cycles.
- R7: ref_req, once high, stays high until a clock edge samples ref_gnt high. On that edge ref_req falls, pin_own rises and the column strobe falls.
- R8: Whenever pin_own is 0 both strobes are 1, and ref_req is never 1 while pin_own is 1. pin_own returns to 0 only after the precharge time has elapsed following a refresh.
- R9: When an interval expires while MAX_OWED refreshes are already pending, overrun rises and seq_ready falls on the same edge. With no grants at all, this happens exactly (MAX_OWED+1)*REFI_CYC cycles after seq_ready rises.
- R10: After an overrun the block requests the pins and, once granted, runs WAKE_CYCLES refreshes. It then raises seq_ready, clears overrun and forgets all pending refreshes, so the next ref_req again comes exactly REFI_CYC+1 cycles after seq_ready.
- R11: An interval expiring on the same cycle that a refresh completes leaves the pending count unchanged. Over any service period the number of serviced refreshes is the number of elapsed intervals or one less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_ready | output | 1 | High once the memory may carry normal traffic |
| ref_req | output | 1 | Request for the strobe pins to run a refresh |
| ref_gnt | input | 1 | Controller grants the pins; sampled while ref_req is high |
| row_strobe_n | output | 1 | Active-low row strobe drive |
| col_strobe_n | output | 1 | Active-low column strobe drive |
| pin_own | output | 1 | High while this block drives the strobe pins |
| overrun | output | 1 | High from a missed-retention event until recovery completes |

## Verification
The two functions that can land on one cycle are the expiry of a refresh interval and the completion of a serviced refresh: one raises the pending count and the other lowers it. The bench provokes this by sweeping the grant latency in steps across most of the interval. Request and completion phases then slide past the interval boundary, and every alignment within the sweep is visited. Each serviced refresh is judged against a lower time bound computed from its index. At the end the serviced total must equal the elapsed intervals or one less, and no overrun may appear. A lost or doubled count shows up as a count mismatch or a spurious overrun.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {
    SQ_PAUSE,
    SQ_WAKE,
    SQ_RUN,
    SQ_RECOV
  } seq_state_t;

  typedef enum logic [1:0] {
    EN_IDLE,
    EN_LEAD,
    EN_ACTIVE,
    EN_PRECH
  } eng_phase_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int REFI_CYC = 3906
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int TW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(REFI_CYC - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/dram_owed_ctr.sv
module dram_owed_ctr #(
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic nonzero,
  output logic over
);
  localparam int OW = $clog2(MAX_OWED + 1);
  localparam logic [OW-1:0] FULL = OW'(MAX_OWED);

  logic [OW-1:0] owed;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      owed <= '0;
    end else if (inc && !dec && owed != FULL) begin
      owed <= owed + 1'b1;
    end else if (dec && !inc && owed != '0) begin
      owed <= owed - 1'b1;
    end
  end

  assign nonzero = (owed != '0);
  assign over    = inc && !dec && (owed == FULL);
endmodule

// File: rtl/dram_colfirst_engine.sv
module dram_colfirst_engine
  import dram_ref_pkg::*;
#(
  parameter int CSR_CYC = 3,
  parameter int CHR_CYC = 3,
  parameter int RAS_CYC = 13,
  parameter int PRE_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic row_n,
  output logic col_n,
  output logic busy,
  output logic done
);
  localparam int SPAN = max_of(max_of(CSR_CYC, RAS_CYC), PRE_CYC);
  localparam int CW   = $clog2(SPAN + 1);
  localparam logic [CW-1:0] LEAD_END = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] HOLD_END = CW'(CHR_CYC - 1);
  localparam logic [CW-1:0] LOW_END  = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] PRE_END  = CW'(PRE_CYC - 1);

  eng_phase_t    ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= EN_IDLE;
      cnt   <= '0;
      row_n <= 1'b1;
      col_n <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        EN_IDLE: begin
          if (start) begin
            col_n <= 1'b0;
            cnt   <= '0;
            ph    <= EN_LEAD;
          end
        end
        EN_LEAD: begin
          if (cnt == LEAD_END) begin
            row_n <= 1'b0;
            cnt   <= '0;
            ph    <= EN_ACTIVE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        EN_ACTIVE: begin
          if (cnt == HOLD_END) col_n <= 1'b1;
          if (cnt == LOW_END) begin
            row_n <= 1'b1;
            cnt   <= '0;
            ph    <= EN_PRECH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == PRE_END) begin
            done <= 1'b1;
            cnt  <= '0;
            ph   <= EN_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy = (ph != EN_IDLE);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYC   = 50000,
  parameter int WAKE_CYCLES = 8,
  parameter int REFI_CYC    = 3906,
  parameter int CSR_CYC     = 3,
  parameter int CHR_CYC     = 3,
  parameter int RAS_CYC     = 13,
  parameter int RP_CYC      = 8,
  parameter int CP_CYC      = 3,
  parameter int MAX_OWED    = 8
) (
  input  logic clk,
  input  logic rst,
  output logic seq_ready,
  output logic ref_req,
  input  logic ref_gnt,
  output logic row_strobe_n,
  output logic col_strobe_n,
  output logic pin_own,
  output logic overrun
);
  localparam int PRE_CYC = max_of(RP_CYC, CP_CYC);
  localparam int PW = (PAUSE_CYC > 2) ? $clog2(PAUSE_CYC) : 1;
  localparam int WW = $clog2(WAKE_CYCLES + 1);
  localparam logic [PW-1:0] PAUSE_END = PW'(PAUSE_CYC - 1);
  localparam logic [WW-1:0] WAKE_END  = WW'(WAKE_CYCLES - 1);

  seq_state_t    st;
  logic [PW-1:0] pcnt;
  logic [WW-1:0] wcnt;

  logic grant, eng_start, eng_busy, eng_done;
  logic tick, owed_nz, owed_over;

  assign grant     = ref_req && ref_gnt;
  assign eng_start = grant || (st == SQ_WAKE && !eng_busy && !eng_done);

  dram_ref_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .en   (st == SQ_RUN),
    .tick (tick)
  );

  dram_owed_ctr #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk     (clk),
    .rst     (rst),
    .clr     (st != SQ_RUN),
    .inc     (tick),
    .dec     (eng_done && st == SQ_RUN),
    .nonzero (owed_nz),
    .over    (owed_over)
  );

  dram_colfirst_engine #(
    .CSR_CYC (CSR_CYC),
    .CHR_CYC (CHR_CYC),
    .RAS_CYC (RAS_CYC),
    .PRE_CYC (PRE_CYC)
  ) u_engine (
    .clk   (clk),
    .rst   (rst),
    .start (eng_start),
    .row_n (row_strobe_n),
    .col_n (col_strobe_n),
    .busy  (eng_busy),
    .done  (eng_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_PAUSE;
      pcnt      <= '0;
      wcnt      <= '0;
      seq_ready <= 1'b0;
      ref_req   <= 1'b0;
      pin_own   <= 1'b1;
      overrun   <= 1'b0;
    end else begin
      case (st)
        SQ_PAUSE: begin
          if (pcnt == PAUSE_END) begin
            st   <= SQ_WAKE;
            wcnt <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        SQ_WAKE: begin
          if (eng_done) begin
            if (wcnt == WAKE_END) begin
              st        <= SQ_RUN;
              seq_ready <= 1'b1;
              overrun   <= 1'b0;
              pin_own   <= 1'b0;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
        end
        SQ_RUN: begin
          if (grant) begin
            ref_req <= 1'b0;
            pin_own <= 1'b1;
          end else if (!pin_own && owed_nz) begin
            ref_req <= 1'b1;
          end
          if (eng_done) pin_own <= 1'b0;
          if (owed_over) begin
            st        <= SQ_RECOV;
            seq_ready <= 1'b0;
            overrun   <= 1'b1;
          end
        end
        default: begin
          if (grant) begin
            ref_req <= 1'b0;
            pin_own <= 1'b1;
            st      <= SQ_WAKE;
            wcnt    <= '0;
          end else if (!pin_own) begin
            ref_req <= 1'b1;
          end
          if (eng_done) pin_own <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk (
  input logic clk,
  input logic rst,
  input logic seq_ready,
  input logic ref_req,
  input logic ref_gnt,
  input logic row_strobe_n,
  input logic col_strobe_n,
  input logic pin_own,
  input logic overrun
);
  AST_REQ_WITHOUT_PINS: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> !pin_own); // R8

  AST_PINS_IDLE_UNOWNED: assert property (@(posedge clk) disable iff (rst)
    !pin_own |-> (row_strobe_n && col_strobe_n)); // R8

  AST_COL_LEADS_ROW: assert property (@(posedge clk) disable iff (rst)
    $fell(row_strobe_n) |-> (!col_strobe_n && $past(!col_strobe_n))); // R4

  AST_OVERRUN_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
    overrun |-> !seq_ready); // R9

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_gnt) |=> ref_req); // R7

  AST_GRANT_TAKES_PINS: assert property (@(posedge clk) disable iff (rst)
    (ref_req && ref_gnt) |=> (pin_own && !col_strobe_n && !ref_req)); // R7

  AST_QUIET_BEFORE_READY: assert property (@(posedge clk) disable iff (rst)
    (!seq_ready && !overrun) |-> !ref_req); // R3
endmodule

bind dram_refresh_seq dram_refresh_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .seq_ready    (seq_ready),
  .ref_req      (ref_req),
  .ref_gnt      (ref_gnt),
  .row_strobe_n (row_strobe_n),
  .col_strobe_n (col_strobe_n),
  .pin_own      (pin_own),
  .overrun      (overrun)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int PAUSE = 20;
  localparam int WAKE  = 8;
  localparam int REFI  = 40;
  localparam int CSR   = 2;
  localparam int CHR   = 2;
  localparam int RASL  = 5;
  localparam int RP    = 3;
  localparam int CP    = 2;
  localparam int MAXO  = 3;
  localparam int PRE   = (RP > CP) ? RP : CP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_gnt = 1'b0;
  logic seq_ready, ref_req, row_n, col_n, pin_own, overrun;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .WAKE_CYCLES(WAKE), .REFI_CYC(REFI),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASL),
    .RP_CYC(RP), .CP_CYC(CP), .MAX_OWED(MAXO)
  ) uut (
    .clk(clk), .rst(rst), .seq_ready(seq_ready), .ref_req(ref_req),
    .ref_gnt(ref_gnt), .row_strobe_n(row_n), .col_strobe_n(col_n),
    .pin_own(pin_own), .overrun(overrun)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int t_rel = 0;
  int t_ready = 0;
  int ref_k = 0;
  int wake_falls = 0;
  int ready_count = 0;
  int row_low_run = 0, row_high_run = 1000, col_low_run = 0, col_high_run = 1000;
  bit first_col_seen = 0, first_req_seen = 0, nogrant_phase = 0, sweep_on = 0;
  bit gnt_en = 0, chk_pend = 0, finished = 0;
  int gnt_dly = 0;
  logic row_p = 1'b1, col_p = 1'b1, ready_p = 1'b0, req_p = 1'b0, ovr_p = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // pin and status monitor, sampled mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        check(pin_own || (row_n && col_n), "R8 strobes idle when not owned",
              {30'd0, row_n, col_n}, 3);
        check(!(ref_req && pin_own), "R8 request while owning", int'(ref_req), 0);
        check(!(ref_req && !seq_ready && !overrun), "R3 request before ready",
              int'(ref_req), 0);
        if (col_p && !col_n) begin
          check(col_high_run >= CP, "R5 column precharge", col_high_run, CP);
          if (!first_col_seen) begin
            first_col_seen = 1;
            check((cyc - t_rel) >= PAUSE && (cyc - t_rel) <= PAUSE + 2,
                  "R2 power-up pause", cyc - t_rel, PAUSE + 1);
          end
        end
        if (row_p && !row_n) begin
          check(!col_n && col_low_run >= CSR, "R4 column lead", col_low_run, CSR);
          check(row_high_run >= PRE, "R5 row precharge", row_high_run, PRE);
          if (!seq_ready) wake_falls++;
          else begin
            ref_k++;
            check((cyc - t_ready) >= REFI * ref_k + 2 + CSR, "R6 refresh not early",
                  cyc - t_ready, REFI * ref_k + 2 + CSR);
          end
        end
        if (!col_p && col_n)
          check(!row_n && row_low_run == CHR, "R4 column hold after row fall",
                row_low_run, CHR);
        if (!row_p && row_n)
          check(row_low_run == RASL, "R5 row low width", row_low_run, RASL);
        if (!ready_p && seq_ready) begin
          ready_count++;
          check(wake_falls == WAKE, ready_count == 1 ? "R3 wake burst count" :
                "R10 recovery burst count", wake_falls, WAKE);
          check(!overrun, "R10 overrun cleared", int'(overrun), 0);
          wake_falls = 0;
          t_ready = cyc;
          ref_k = 0;
          first_req_seen = 0;
        end
        if (!req_p && ref_req && seq_ready && !first_req_seen) begin
          first_req_seen = 1;
          check((cyc - t_ready) == REFI + 1, ready_count == 1 ? "R6 first request" :
                "R10 first request after recovery", cyc - t_ready, REFI + 1);
        end
        if (!ovr_p && overrun) begin
          check(!seq_ready, "R9 ready drops with overrun", int'(seq_ready), 0);
          check(!sweep_on, "R11 no overrun during sweep", 1, 0);
          if (nogrant_phase)
            check((cyc - t_ready) == (MAXO + 1) * REFI, "R9 overrun time",
                  cyc - t_ready, (MAXO + 1) * REFI);
          wake_falls = 0;
        end
      end
      row_low_run  = row_n ? 0 : row_low_run + 1;
      row_high_run = row_n ? row_high_run + 1 : 0;
      col_low_run  = col_n ? 0 : col_low_run + 1;
      col_high_run = col_n ? col_high_run + 1 : 0;
      row_p = row_n; col_p = col_n; ready_p = seq_ready; req_p = ref_req; ovr_p = overrun;
    end
  end

  // controller model: grants after gnt_dly cycles of request
  initial begin
    int wait_c;
    wait_c = 0;
    forever begin
      @(negedge clk);
      if (chk_pend) begin
        chk_pend = 0;
        check(!ref_req && pin_own && !col_n, "R7 grant takes pins",
              {29'd0, ref_req, pin_own, col_n}, 2);
      end
      if (ref_gnt) begin
        ref_gnt = 1'b0;
        wait_c = 0;
      end else if (gnt_en && ref_req) begin
        if (wait_c >= gnt_dly) begin
          ref_gnt = 1'b1;
          chk_pend = 1;
        end else begin
          wait_c++;
        end
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!seq_ready && !ref_req && !overrun && row_n && col_n && pin_own,
          "R1 reset state", {26'd0, seq_ready, ref_req, overrun, row_n, col_n, pin_own}, 7);
    rst = 1'b0;
    t_rel = cyc;
    @(negedge clk);
    check(!seq_ready && !ref_req && !overrun && row_n && col_n && pin_own,
          "R1 state after release", {26'd0, seq_ready, ref_req, overrun, row_n, col_n, pin_own}, 7);
    nogrant_phase = 1;
    wait (overrun == 1'b1);
    @(negedge clk);
    nogrant_phase = 0;
    gnt_en = 1;
    gnt_dly = 0;
    wait (seq_ready == 1'b1);
    @(negedge clk);
    sweep_on = 1;
    for (int d = 0; d <= 27; d += 3) begin
      gnt_dly = d;
      repeat (3 * REFI) @(negedge clk);
    end
    begin
      int ticks;
      ticks = (cyc - t_ready) / REFI;
      check(ref_k == ticks || ref_k == ticks - 1, "R11 serviced versus elapsed",
            ref_k, ticks);
    end
    check(!overrun && seq_ready, "R11 still in service", int'(overrun), 0);
    finish_run();
  end
endmodule